// File: doc/BRIEF.md
# Pin I/O Controller with Filtered Interrupt Detection

This block drives and samples a bank of general-purpose pins through a word-wide register port. Software writes an output word and a per-pin output-enable word. It can also change single output bits without a read-modify-write, using a write-one-to-set word and a write-one-to-clear word. Input pins pass through a two-stage synchronizer before they are read back or examined for interrupts.

Each pin can raise an interrupt on a rising edge, a falling edge, both edges, a high level or a low level. Edge events are held in a raw status word until software clears them. Level events follow the pin. A per-pin enable and a per-pin mask produce the masked status, and the interrupt line is the OR of the masked status. An optional per-pin glitch filter uses one shared prescale value. A filtered pin accepts a new value only after the synchronized input has held that value for the prescale number of cycles. If a pin has filtering on while the prescale is zero, that pin detects nothing.

Register reads are combinational from the address. Writes take effect at the clock edge on which the write strobe is high.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After a synchronous reset, every register is zero. `pin_out`, `pin_oe` and `irq` are 0, and the raw status (0x24) reads 0.
- R2: A write to 0x00 loads the output word onto `pin_out`. A write to 0x08 loads `pin_oe`, where 1 makes a pin an output. Both words read back as written.
- R3: A write to 0x10 ORs the written 1 bits into the output word. A write to 0x14 clears the written 1 bits. All other bits are unchanged, and both addresses read as 0.
- R4: Address 0x04 returns `pin_in` delayed by a two-flop synchronizer: a change becomes visible after the second clock edge. Writes to 0x04 have no effect.
- R5: When a pin's bit in 0x34 is 0 (edge mode), a bit value of 0 in 0x3C detects a rising edge and 1 detects a falling edge. Detected edges latch in raw status 0x24.
- R6: When a pin's bit in 0x38 is 1, either edge of that pin latches its raw status bit.
- R7: When a pin's bit in 0x34 is 1 (level mode), its raw bit follows the pin: high when the 0x3C bit is 0, low when it is 1. A clear write does not remove a level indication.
- R8: Writing 1 bits to 0x30 clears those latched edge bits. Bits written as 0 stay latched.
- R9: Masked status 0x28 equals raw AND enable (0x20) AND NOT mask (0x2C). `irq` is the OR of the masked status.
- R10: When a pin's bit in 0x40 is 1 and the prescale P in 0x44 bits 15:0 is non-zero, a new input value is accepted only after it has held for P cycles. Shorter pulses raise no event.
- R11: When a pin's bit in 0x40 is 1 and P is 0, that pin raises no edge or level event.
- R12: Registers 0x20, 0x2C, 0x34, 0x38, 0x3C and 0x40 read back as written. Address 0x44 reads back bits 15:0 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pin_in | input | NPIN | Asynchronous pin inputs |
| pin_out | output | NPIN | Output data word |
| pin_oe | output | NPIN | Per-pin output enable |
| irq | output | 1 | Interrupt request, OR of masked status |

## Verification
The bound assertions check the output word on every cycle. They confirm the set and clear arithmetic and direct loads, and that `pin_out` stays put when nothing addresses it. They also check that `irq` never rises without an enabled, unmasked raw bit, and that a pin with filtering on and a zero prescale never gains a raw bit. Only the bench scenarios can show that detection is correct for each trigger type. They also cover the synchronizer latency, rejection of short pulses by the filter, and how raw, masked and clear interact.

// File: rtl/gpio_pkg.sv
// Shared constants for the pin I/O controller: register offsets and bus widths.
// Assumes a byte-addressed, word-aligned register port.
package gpio_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_DOUT   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DIN    = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_OE     = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_SET    = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CLR    = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_IEN    = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_IRAW   = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_IMSK_S = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_IMASK  = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_ICLR   = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_TRIG   = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_BOTH   = 8'h38;
    localparam logic [ADDR_W-1:0] OFS_POL    = 8'h3C;
    localparam logic [ADDR_W-1:0] OFS_FILT   = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_PSCL   = 8'h44;
endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchronizer for a bank of asynchronous inputs.
// Assumes each bit is independent; no bus coherence is implied.
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    // Shift the inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_filter.sv
// Per-pin glitch filter with a shared prescale. A pin's filtered value
// follows the input only after the input has differed from it for PSCL
// consecutive cycles. With the filter on and PSCL zero, the value is frozen.
// Assumes synchronized inputs.
module gpio_filter #(
    parameter int W    = 32,
    parameter int PS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W-1:0]    din,
    input  logic [W-1:0]    en,
    input  logic [PS_W-1:0] pscl,
    output logic [W-1:0]    dout
);
    localparam logic [PS_W-1:0] ONE = PS_W'(1);
    logic pscl_zero;
    assign pscl_zero = (pscl == '0);

    for (genvar g = 0; g < W; g++) begin : g_pin
        logic [PS_W-1:0] cnt_q;
        logic            filt_q;

        // Count cycles of disagreement and accept the input once the period is reached.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q  <= '0;
                filt_q <= 1'b0;
            end else if (!en[g]) begin
                cnt_q  <= '0;
                filt_q <= din[g];
            end else if (pscl_zero || din[g] == filt_q) begin
                cnt_q  <= '0;
            end else if (cnt_q == pscl - ONE) begin
                cnt_q  <= '0;
                filt_q <= din[g];
            end else begin
                cnt_q  <= cnt_q + ONE;
            end
        end

        assign dout[g] = en[g] ? filt_q : din[g];
    end
endmodule

// File: rtl/gpio_irq_detect.sv
// Per-pin interrupt detection. Edge events latch until cleared; level
// events are combinational from the pin. A gate input blocks all events.
// Assumes the level input is already synchronized and filtered.
module gpio_irq_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] trig_lvl,
    input  logic [W-1:0] both,
    input  logic [W-1:0] pol_low,
    input  logic [W-1:0] gate,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] raw
);
    logic [W-1:0] prev_q;
    logic [W-1:0] edge_q;
    logic [W-1:0] rise, fall, edge_hit, lvl_hit, clr_vec;

    assign rise     = level & ~prev_q;
    assign fall     = ~level & prev_q;
    assign edge_hit = (both & (rise | fall)) | (~both & ((pol_low & fall) | (~pol_low & rise)));
    assign lvl_hit  = (level ^ pol_low) & gate;
    assign clr_vec  = clr_wr ? clr_bits : '0;

    // Remember the previous pin value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    // Latch edge events; a clear drops bits, a new event in the same cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n) edge_q <= '0;
        else        edge_q <= (edge_q & ~clr_vec) | (edge_hit & gate & ~trig_lvl);
    end

    assign raw = (trig_lvl & lvl_hit) | (~trig_lvl & edge_q);
endmodule

// File: rtl/gpio_irq_ctrl.sv
// Top of the pin I/O controller: register file, output data path,
// synchronizer, glitch filter and interrupt detection.
// Assumes reads are combinational and writes are single-cycle strobes.
module gpio_irq_ctrl
    import gpio_pkg::*;
#(
    parameter int NPIN   = 32,
    parameter int PS_W   = 16,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic              irq
);
    logic [NPIN-1:0] dout_q, oe_q, int_en_q, int_mask_q, trig_q, both_q, pol_q, deb_en_q;
    logic [PS_W-1:0] prescale_q;
    logic [NPIN-1:0] wbits, pin_sync, pin_filt, gate, irq_raw, irq_msk;
    logic            clr_wr;

    assign wbits  = reg_wdata[NPIN-1:0];
    assign clr_wr = reg_wr && (reg_addr == OFS_ICLR);

    // Register writes, including the atomic set and clear of the output word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q     <= '0;
            oe_q       <= '0;
            int_en_q   <= '0;
            int_mask_q <= '0;
            trig_q     <= '0;
            both_q     <= '0;
            pol_q      <= '0;
            deb_en_q   <= '0;
            prescale_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_DOUT:  dout_q     <= wbits;
                OFS_SET:   dout_q     <= dout_q | wbits;
                OFS_CLR:   dout_q     <= dout_q & ~wbits;
                OFS_OE:    oe_q       <= wbits;
                OFS_IEN:   int_en_q   <= wbits;
                OFS_IMASK: int_mask_q <= wbits;
                OFS_TRIG:  trig_q     <= wbits;
                OFS_BOTH:  both_q     <= wbits;
                OFS_POL:   pol_q      <= wbits;
                OFS_FILT:  deb_en_q   <= wbits;
                OFS_PSCL:  prescale_q <= reg_wdata[PS_W-1:0];
                default:   ;
            endcase
        end
    end

    gpio_sync #(.W(NPIN), .STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    gpio_filter #(.W(NPIN), .PS_W(PS_W)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_sync),
        .en    (deb_en_q),
        .pscl  (prescale_q),
        .dout  (pin_filt)
    );

    assign gate = ~(deb_en_q & {NPIN{prescale_q == '0}});

    gpio_irq_detect #(.W(NPIN)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (pin_filt),
        .trig_lvl (trig_q),
        .both     (both_q),
        .pol_low  (pol_q),
        .gate     (gate),
        .clr_wr   (clr_wr),
        .clr_bits (wbits),
        .raw      (irq_raw)
    );

    assign irq_msk = irq_raw & int_en_q & ~int_mask_q;
    assign irq     = |irq_msk;
    assign pin_out = dout_q;
    assign pin_oe  = oe_q;

    // Read multiplexer; write-only and unused addresses return zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_DOUT:   reg_rdata = DATA_W'(dout_q);
            OFS_DIN:    reg_rdata = DATA_W'(pin_sync);
            OFS_OE:     reg_rdata = DATA_W'(oe_q);
            OFS_IEN:    reg_rdata = DATA_W'(int_en_q);
            OFS_IRAW:   reg_rdata = DATA_W'(irq_raw);
            OFS_IMSK_S: reg_rdata = DATA_W'(irq_msk);
            OFS_IMASK:  reg_rdata = DATA_W'(int_mask_q);
            OFS_TRIG:   reg_rdata = DATA_W'(trig_q);
            OFS_BOTH:   reg_rdata = DATA_W'(both_q);
            OFS_POL:    reg_rdata = DATA_W'(pol_q);
            OFS_FILT:   reg_rdata = DATA_W'(deb_en_q);
            OFS_PSCL:   reg_rdata = DATA_W'(prescale_q);
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
// Checker for gpio_irq_ctrl: cycle-level properties of the output word
// and the interrupt line. Attached by bind below.
module gpio_irq_ctrl_chk
    import gpio_pkg::*;
#(
    parameter int NPIN = 32,
    parameter int PS_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [NPIN-1:0]   pin_out,
    input logic [NPIN-1:0]   pin_oe,
    input logic              irq,
    input logic [NPIN-1:0]   irq_raw,
    input logic [NPIN-1:0]   int_en,
    input logic [NPIN-1:0]   int_mask,
    input logic [NPIN-1:0]   deb_en,
    input logic [PS_W-1:0]   prescale
);
    logic [NPIN-1:0] sup;
    logic            touches_out;
    assign sup = deb_en & {NPIN{prescale == '0}};
    assign touches_out = reg_wr && (reg_addr == OFS_DOUT || reg_addr == OFS_SET || reg_addr == OFS_CLR);

    p_dout_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_DOUT) |=> pin_out == $past(reg_wdata[NPIN-1:0]));
    p_oe_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_OE) |=> pin_oe == $past(reg_wdata[NPIN-1:0]));
    p_set_or_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_SET) |=> pin_out == ($past(pin_out) | $past(reg_wdata[NPIN-1:0])));
    p_clr_and_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_CLR) |=> pin_out == ($past(pin_out) & ~$past(reg_wdata[NPIN-1:0])));
    p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !touches_out |=> $stable(pin_out));
    p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_raw & int_en & ~int_mask) != '0);
    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_raw == '0) |-> !irq);
    p_suppress_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_raw & ~$past(irq_raw) & sup & $past(sup)) == '0);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPIN(NPIN), .PS_W(PS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .irq_raw   (irq_raw),
    .int_en    (int_en_q),
    .int_mask  (int_mask_q),
    .deb_en    (deb_en_q),
    .prescale  (prescale_q)
);

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_irq_ctrl i_gpio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // op: 0 write, 1 read compare, 2 compare pin_out, 3 compare pin_oe
    localparam int NV = 16;
    localparam logic [73:0] VEC [NV] = '{
        {2'd0, 8'h00, 32'h0000_00F0, 32'h0},          // R2 load output word
        {2'd2, 8'h00, 32'h0,         32'h0000_00F0},  // R2
        {2'd0, 8'h10, 32'h0000_0F0F, 32'h0},          // R3 set
        {2'd2, 8'h00, 32'h0,         32'h0000_0FFF},  // R3
        {2'd0, 8'h14, 32'h0000_00A0, 32'h0},          // R3 clear
        {2'd2, 8'h00, 32'h0,         32'h0000_0F5F},  // R3
        {2'd1, 8'h00, 32'h0,         32'h0000_0F5F},  // R2 readback
        {2'd1, 8'h10, 32'h0,         32'h0},          // R3 write-only reads 0
        {2'd1, 8'h14, 32'h0,         32'h0},          // R3
        {2'd0, 8'h08, 32'hFFFF_0000, 32'h0},          // R2 direction
        {2'd3, 8'h00, 32'h0,         32'hFFFF_0000},  // R2
        {2'd0, 8'h44, 32'hABCD_1234, 32'h0},          // R12 prescale
        {2'd1, 8'h44, 32'h0,         32'h0000_1234},  // R12 upper bits zero
        {2'd0, 8'h04, 32'hFFFF_FFFF, 32'h0},          // R4 write ignored
        {2'd1, 8'h04, 32'h0,         32'h0},          // R4
        {2'd0, 8'h2C, 32'h1234_5678, 32'h0}           // R12 mask storage
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pins(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    logic [31:0] rv;

    initial begin
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pin_out", pin_out, 32'h0);
        chk("R1 pin_oe", pin_oe, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        rd(8'h24, rv); chk("R1 raw", rv, 32'h0);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][73:72])
                2'd0: wr(VEC[i][71:64], VEC[i][63:32]);
                2'd1: begin rd(VEC[i][71:64], rv); chk("R2/R3/R4/R12 vector read", rv, VEC[i][31:0]); end
                2'd2: chk("R2/R3 vector pin_out", pin_out, VEC[i][31:0]);
                default: chk("R2 vector pin_oe", pin_oe, VEC[i][31:0]);
            endcase
        end
        rd(8'h2C, rv); chk("R12 mask readback", rv, 32'h1234_5678);
        wr(8'h2C, 32'h0);
        wr(8'h44, 32'h0);

        // R4 synchronizer latency
        pins(32'h0000_8001);
        rd(8'h04, rv); chk("R4 before edges", rv, 32'h0);
        @(negedge clk); rd(8'h04, rv); chk("R4 after one edge", rv, 32'h0);
        @(negedge clk); rd(8'h04, rv); chk("R4 after two edges", rv, 32'h0000_8001);
        pins(32'h0); cyc(4);
        wr(8'h30, 32'hFFFF_FFFF);

        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h3C, 32'h0000_0012);          // pins 1 and 4 falling/low
        // R5 rising on pin 0
        pins(32'h1); cyc(4);
        rd(8'h24, rv); chk("R5 rise latched", rv, 32'h1);
        chk("R9 irq on", {31'h0, irq}, 32'h1);
        pins(32'h0); cyc(4);
        rd(8'h24, rv); chk("R5 held after fall", rv, 32'h1);
        wr(8'h30, 32'h1);
        rd(8'h24, rv); chk("R8 cleared", rv, 32'h0);
        chk("R9 irq off", {31'h0, irq}, 32'h0);
        // R5 falling on pin 1
        pins(32'h2); cyc(4);
        rd(8'h24, rv); chk("R5 rise ignored on falling pin", rv, 32'h0);
        pins(32'h0); cyc(4);
        rd(8'h24, rv); chk("R5 fall latched", rv, 32'h2);
        wr(8'h30, 32'h2);
        // R6 both edges on pin 2
        wr(8'h38, 32'h4);
        pins(32'h4); cyc(4);
        rd(8'h24, rv); chk("R6 rise", rv, 32'h4);
        wr(8'h30, 32'h4);
        pins(32'h0); cyc(4);
        rd(8'h24, rv); chk("R6 fall", rv, 32'h4);
        // R8 partial clear: latch pin 0 too, clear only pin 0
        pins(32'h1); cyc(4);
        wr(8'h30, 32'h1);
        rd(8'h24, rv); chk("R8 partial clear", rv, 32'h4);
        pins(32'h0); cyc(4);
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h38, 32'h0);

        // R7 level high on pin 3
        wr(8'h34, 32'h8);
        pins(32'h8); cyc(4);
        rd(8'h24, rv); chk("R7 high level", rv, 32'h8);
        wr(8'h30, 32'h8);
        rd(8'h24, rv); chk("R7 clear ignored", rv, 32'h8);
        pins(32'h0); cyc(4);
        rd(8'h24, rv); chk("R7 follows pin", rv, 32'h0);
        // R7 level low on pin 4
        wr(8'h34, 32'h10); cyc(2);
        rd(8'h24, rv); chk("R7 low level", rv, 32'h10);
        pins(32'h10); cyc(4);
        rd(8'h24, rv); chk("R7 low released", rv, 32'h0);
        pins(32'h0);
        wr(8'h34, 32'h0); cyc(4);
        wr(8'h30, 32'hFFFF_FFFF);

        // R9 mask and enable on pin 5
        wr(8'h2C, 32'h20);
        pins(32'h20); cyc(4);
        rd(8'h24, rv); chk("R9 raw set", rv, 32'h20);
        rd(8'h28, rv); chk("R9 masked hidden", rv, 32'h0);
        chk("R9 irq masked", {31'h0, irq}, 32'h0);
        wr(8'h2C, 32'h0);
        rd(8'h28, rv); chk("R9 masked shown", rv, 32'h20);
        chk("R9 irq unmasked", {31'h0, irq}, 32'h1);
        wr(8'h20, 32'hFFFF_FFDF);
        chk("R9 irq disabled", {31'h0, irq}, 32'h0);
        wr(8'h20, 32'hFFFF_FFFF);
        pins(32'h0); cyc(4);
        wr(8'h30, 32'hFFFF_FFFF);

        // R10 filter on pin 6, prescale 8
        wr(8'h40, 32'hC0);
        wr(8'h44, 32'h8);
        pins(32'h40); cyc(3);
        pins(32'h0); cyc(20);
        rd(8'h24, rv); chk("R10 short pulse rejected", rv, 32'h0);
        pins(32'h40); cyc(20);
        rd(8'h24, rv); chk("R10 long pulse accepted", rv, 32'h40);
        pins(32'h0); cyc(20);
        wr(8'h30, 32'hFFFF_FFFF);

        // R11 zero prescale suppresses pin 7
        wr(8'h44, 32'h0);
        pins(32'h80); cyc(20);
        rd(8'h24, rv); chk("R11 edge suppressed", rv, 32'h0);
        wr(8'h34, 32'h80); cyc(2);
        rd(8'h24, rv); chk("R11 level suppressed", rv, 32'h0);
        chk("R11 irq quiet", {31'h0, irq}, 32'h0);
        wr(8'h44, 32'h8); cyc(20);
        rd(8'h24, rv); chk("R10 level after prescale restored", rv, 32'h80);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule